// File: doc/BRIEF.md
# Asynchronous Static Memory Write Sequencer

This block turns a single write request into a correctly timed asynchronous write cycle on an external static memory bus. The bus can carry SRAM, ROM or flash. A request carries a word-aligned byte address, one data word, active-low byte lane masks and a beat count. The block then drives chip select, write enable and an address-valid strobe, all active low. Output enable is held inactive. Every strobe edge falls on a memory clock edge. The spacing between edges is a whole number of clock periods, and each spacing is set by a parameter.

A multi-beat request produces one write-enable pulse per beat, and chip select stays low across all of them. Write enable is forced high for a gap between beats. The block raises `beat_take` in the first cycle of that gap, and the requester must present the next data word and mask on the request inputs by that clock edge. On the same edge the block steps the address by one word.

When chip select has been released and the address hold has elapsed, the block pulses `wr_done` and is ready for the next request.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `wr_done` is 0, and `mem_cs_n`, `mem_we_n`, `mem_adv_n` and `mem_oe_n` are all 1.
- R2: On the accepting clock edge (`req_valid` and `req_ready` both 1), address, data and mask go onto the memory bus. `T_ADDR` (default 1) clocks later, chip select and the address-valid strobe fall. The address-valid strobe stays low for exactly one clock.
- R3: The first write-enable fall comes `T_CSWE` (default 2) clocks after chip select falls. The address has then been stable for at least three clocks.
- R4: Each write-enable low pulse lasts exactly `WE_LOW` clocks (at least 1).
- R5: Between beats, write enable stays high for exactly `WE_GAP` clocks (at least 4) while chip select stays low.
- R6: `beat_take` is 1 in the first clock of each inter-beat gap and at no other time. The clock edge that ends that cycle loads the next data word and mask from the request inputs and adds 4 to the address, wrapping at the address width.
- R7: Chip select rises one clock after the last write-enable rise. `wr_done` is a one-clock pulse one clock after that.
- R8: `mem_oe_n` stays 1 throughout.
- R9: A beat count of N (4-bit field) gives exactly N write-enable pulses. A count of 0 behaves as 1.
- R10: `req_ready` is 0 from the accepting edge until `wr_done` is seen, and returns to 1 with it. Request inputs other than the per-beat data and mask are ignored while `req_ready` is 0.
- R11: Address, data and mask do not change while write enable is low, or in the clock after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Byte address of first beat |
| req_wdata | input | DATA_W | Write data (first beat, then each taken beat) |
| req_be_n | input | DATA_W/8 | Byte lane masks, active low |
| req_beats | input | BEAT_W | Beat count, 0 means 1 |
| beat_take | output | 1 | Next data word and mask are loaded at the end of this cycle |
| wr_done | output | 1 | One-clock pulse at end of the write cycle |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_wdata | output | DATA_W | Memory write data bus |
| mem_be_n | output | DATA_W/8 | Memory byte masks |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, held high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |

## Verification
The bench builds the block with `WE_LOW` set to 3 and the other intervals at their defaults. Because the write-enable width then differs from the chip-select setup, an off-by-one in either interval shows up in a different cycle. With a beat period of seven clocks, the bench predicts every strobe, bus value and `beat_take` cycle by cycle. It covers single and multi-beat writes, a zero beat count, and a fifteen-beat write whose address wraps past the top of the 26-bit space. It also covers a request held valid with a changed address while the block is busy.

// File: rtl/swr_pkg.sv
package swr_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_CSSU,
      S_WELO,
      S_WEGAP,
      S_HOLD,
      S_DONE
   } swr_state_e;

   localparam int TMR_ADDR = 0;
   localparam int TMR_CSSU = 1;
   localparam int TMR_WELO = 2;
   localparam int TMR_GAP  = 3;
   localparam int TMR_NUM  = 4;

endpackage

// File: rtl/swr_tick.sv
module swr_tick #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic last
);
   localparam int W = (LEN > 1) ? $clog2(LEN) : 1;

   if (LEN < 1) begin : g_bad_len
      $error("swr_tick: LEN must be at least 1");
   end

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= W'(LEN - 1);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/swr_path.sv
module swr_path #(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int MASK_W = 4,
   parameter int BEAT_W = 4,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [MASK_W-1:0] in_mask,
   input  logic [BEAT_W-1:0] in_beats,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic [MASK_W-1:0] mask,
   output logic              last_beat
);
   logic [BEAT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         data <= '0;
         mask <= '1;
         left <= BEAT_W'(1);
      end else if (load) begin
         addr <= in_addr;
         data <= in_data;
         mask <= in_mask;
         left <= (in_beats == '0) ? BEAT_W'(1) : in_beats;
      end else if (step) begin
         addr <= addr + ADDR_W'(STEP);
         data <= in_data;
         mask <= in_mask;
         left <= left - 1'b1;
      end
   end

   assign last_beat = (left == BEAT_W'(1));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
   import swr_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int BEAT_W = 4,
   parameter int T_ADDR = 1,
   parameter int T_CSWE = 2,
   parameter int WE_LOW = 2,
   parameter int WE_GAP = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_be_n,
   input  logic [BEAT_W-1:0]     req_beats,
   output logic                  beat_take,
   output logic                  wr_done,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic [DATA_W/8-1:0]   mem_be_n,
   output logic                  mem_cs_n,
   output logic                  mem_oe_n,
   output logic                  mem_we_n,
   output logic                  mem_adv_n
);
   localparam int MASK_W = DATA_W / 8;
   localparam int STEP   = MASK_W;

   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("sram_wr_seq: DATA_W must be a multiple of 8");
   end
   if (T_ADDR < 1 || T_CSWE < 2 || T_ADDR + T_CSWE < 3) begin : g_bad_setup
      $error("sram_wr_seq: setup intervals too short");
   end
   if (WE_LOW < 1) begin : g_bad_low
      $error("sram_wr_seq: WE_LOW must be at least 1");
   end
   if (WE_GAP < 4) begin : g_bad_gap
      $error("sram_wr_seq: WE_GAP must cover address hold plus setup");
   end

   function automatic int tlen(input int k);
      case (k)
         TMR_ADDR: return T_ADDR;
         TMR_CSSU: return T_CSWE;
         TMR_WELO: return WE_LOW;
         default:  return WE_GAP;
      endcase
   endfunction

   swr_state_e         state, nstate;
   logic [TMR_NUM-1:0] t_start, t_last;
   logic               accept, step, last_beat, gap_entry;

   for (genvar k = 0; k < TMR_NUM; k++) begin : g_tmr
      swr_tick #(.LEN(tlen(k))) u_tick (
         .clk   (clk),
         .rst_n (rst_n),
         .start (t_start[k]),
         .last  (t_last[k])
      );
   end

   swr_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W),
      .BEAT_W (BEAT_W),
      .STEP   (STEP)
   ) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .step      (step),
      .in_addr   (req_addr),
      .in_data   (req_wdata),
      .in_mask   (req_be_n),
      .in_beats  (req_beats),
      .addr      (mem_addr),
      .data      (mem_wdata),
      .mask      (mem_be_n),
      .last_beat (last_beat)
   );

   always_comb begin
      nstate  = state;
      t_start = '0;
      accept  = 1'b0;
      step    = 1'b0;
      case (state)
         S_IDLE: if (req_valid) begin
            nstate = S_ADDR;
            accept = 1'b1;
            t_start[TMR_ADDR] = 1'b1;
         end
         S_ADDR: if (t_last[TMR_ADDR]) begin
            nstate = S_CSSU;
            t_start[TMR_CSSU] = 1'b1;
         end
         S_CSSU: if (t_last[TMR_CSSU]) begin
            nstate = S_WELO;
            t_start[TMR_WELO] = 1'b1;
         end
         S_WELO: if (t_last[TMR_WELO]) begin
            if (last_beat) begin
               nstate = S_HOLD;
            end else begin
               nstate = S_WEGAP;
               t_start[TMR_GAP] = 1'b1;
            end
         end
         S_WEGAP: begin
            step = gap_entry;
            if (t_last[TMR_GAP]) begin
               nstate = S_WELO;
               t_start[TMR_WELO] = 1'b1;
            end
         end
         S_HOLD:  nstate = S_DONE;
         S_DONE:  nstate = S_IDLE;
         default: nstate = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         gap_entry <= 1'b0;
         mem_cs_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_adv_n <= 1'b1;
         req_ready <= 1'b1;
         wr_done   <= 1'b0;
      end else begin
         state     <= nstate;
         gap_entry <= (nstate == S_WEGAP) && (state != S_WEGAP);
         mem_cs_n  <= !(nstate inside {S_CSSU, S_WELO, S_WEGAP, S_HOLD});
         mem_we_n  <= (nstate != S_WELO);
         mem_adv_n <= !((state == S_ADDR) && (nstate == S_CSSU));
         req_ready <= (nstate == S_IDLE);
         wr_done   <= (state == S_DONE);
      end
   end

   assign mem_oe_n  = 1'b1;
   assign beat_take = step;

   // Timing rules checked against the bus
   p_cs_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs_n) |-> $stable(mem_addr));
   p_adv_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_adv_n |-> !mem_cs_n ##1 mem_adv_n);
   p_we_under_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> (!mem_cs_n && $past(!mem_cs_n)));
   p_gap_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> mem_we_n);
   p_step_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      beat_take |=> (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));
   p_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> (mem_we_n && $past(mem_we_n)));
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> (req_ready && mem_cs_n));
   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_bus_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be_n)));

endmodule

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;
   localparam int AW = 26;
   localparam int DW = 32;
   localparam int MW = DW / 8;
   localparam int BW = 4;
   localparam int TA = 1;
   localparam int TC = 2;
   localparam int TL = 3;
   localparam int TG = 4;
   localparam int P  = TL + TG;
   localparam int F  = TA + TC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready, beat_take, wr_done;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [MW-1:0] req_be_n = '0;
   logic [BW-1:0] req_beats = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [MW-1:0] mem_be_n;
   logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sram_wr_seq #(.WE_LOW(TL)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be_n(req_be_n),
      .req_beats(req_beats), .beat_take(beat_take), .wr_done(wr_done),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be_n(mem_be_n),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_adv_n(mem_adv_n)
   );

   task automatic chk(input string req, input string what, input int cyc,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
      end
   endtask

   // One write of n beats; cycle i counts negedges after the accepting edge
   task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [MW-1:0] m, input int beats, input bit hold_valid);
      int n = (beats == 0) ? 1 : beats;
      int r = F + P * (n - 1) + TL;
      int pulses = 0;
      logic prev_we = 1'b1;
      @(negedge clk);
      req_addr  = a;
      req_wdata = d;
      req_be_n  = m;
      req_beats = BW'(beats);
      req_valid = 1'b1;
      @(posedge clk);
      for (int i = 0; i <= r + 2; i++) begin
         int k = 0;
         bit we_lo = 1'b0;
         bit take = 1'b0;
         bit in_gap = 1'b0;
         logic [AW-1:0] ea;
         @(negedge clk);
         if (!hold_valid) req_valid = 1'b0;
         else req_addr = ~a;
         for (int b = 0; b < n; b++) begin
            if (i >= F + P * b && i < F + P * b + TL) we_lo = 1'b1;
            if (b < n - 1 && i == F + P * b + TL) take = 1'b1;
            if (b < n - 1 && i >= F + P * b + TL && i < F + P * (b + 1)) in_gap = 1'b1;
            if (b < n - 1 && i >= F + P * b + TL + 1) k++;
         end
         ea = a + AW'(4 * k);
         if (!mem_we_n === 1'b0 && prev_we === 1'b1) begin end
         if (mem_we_n === 1'b0 && prev_we === 1'b1) pulses++;
         prev_we = mem_we_n;
         chk((we_lo || take) ? "R11" : "R6", "addr", i, mem_addr, ea);
         chk((we_lo || take) ? "R11" : "R6", "data", i, mem_wdata, d + DW'(k));
         chk((we_lo || take) ? "R11" : "R6", "mask", i, mem_be_n, m ^ MW'(k));
         chk("R6", "beat_take", i, beat_take, take);
         chk(i <= F ? "R3" : (in_gap ? "R5" : "R4"), "we_n", i, mem_we_n, !we_lo);
         chk(i < TA ? "R2" : "R7", "cs_n", i, mem_cs_n, !(i >= TA && i <= r));
         chk("R2", "adv_n", i, mem_adv_n, !(i == TA));
         chk("R8", "oe_n", i, mem_oe_n, 1);
         chk("R10", "req_ready", i, req_ready, i == r + 2);
         chk("R7", "wr_done", i, wr_done, i == r + 2);
         if (take) begin
            req_wdata = d + DW'(k + 1);
            req_be_n  = m ^ MW'(k + 1);
         end
         if (i == r + 2) req_valid = 1'b0;
      end
      chk("R9", "we pulse count", r + 2, pulses, n);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "req_ready", 0, req_ready, 1);
      chk("R1", "wr_done", 0, wr_done, 0);
      chk("R1", "cs_n", 0, mem_cs_n, 1);
      chk("R1", "we_n", 0, mem_we_n, 1);
      chk("R1", "adv_n", 0, mem_adv_n, 1);
      chk("R1", "oe_n", 0, mem_oe_n, 1);
      rst_n = 1'b1;
   endtask

   task automatic t_single;  run_write(26'h0001230, 32'hA5A5_0000, 4'b0000, 1, 1'b0);  endtask
   task automatic t_multi;   run_write(26'h0100000, 32'h1234_5670, 4'b0101, 3, 1'b0);  endtask
   task automatic t_zero;    run_write(26'h0000040, 32'hDEAD_BEE0, 4'b1100, 0, 1'b0);  endtask // R9
   task automatic t_busy;    run_write(26'h0200008, 32'h0F0F_0F00, 4'b0011, 2, 1'b1);  endtask // R10
   task automatic t_long;    run_write(26'h3FFFFF8, 32'h7700_0000, 4'b1000, 15, 1'b0); endtask // R6 wrap

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      t_multi();
      t_zero();
      t_busy();
      t_long();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule